// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block turns an asynchronous serial line into parallel characters. It has no clock recovery of its own. The line is looked at once per sample tick, and the tick runs a fixed multiple faster than the bit rate. A resting line sits high. A character opens when the line drops low. The drop only counts once the line has stayed low for half a bit time; a shorter dip is treated as noise. After a start is accepted, the block takes one sample per bit time, so each bit is read near its middle. It gathers 5 to 9 data bits, least significant first. It then checks an optional parity bit and the stop bit.

Each character goes to the host with a valid flag. That flag, and all the error flags, stay set until the host pulses an acknowledge. The error flags cover parity, framing, break and overrun. The number of ticks per bit can be changed at run time. A new value is taken only when the receiver is idle and the line is high. A write at any other time is dropped.

Top module: `serial_rx`

## Requirements
- R1: After reset, `rx_valid`, `par_err`, `frame_err`, `overrun`, `brk` and `busy` are all 0, and `len_cur` equals the default ticks-per-bit of 8.
- R2: A low pulse on `rxd` that lasts fewer sample ticks than half a bit time is discarded. The receiver returns to idle (`busy` = 0) and sets no flag.
- R3: Data bits are taken least significant first. Each is sampled `len_cur` ticks after the previous one, the first one a full bit time after the start is qualified. A character with a high stop bit sets `rx_valid` and appears on `rx_data`, right-aligned with zeros above it.
- R4: `cfg_bits` selects the data length. Values 5 to 9 are used as given, values below 5 act as 5, and values above 9 act as 9. The length is taken when a start bit is first seen.
- R5: When `cfg_par_en` = 1 and the length is below 9, one parity bit follows the data. `cfg_par_odd` = 0 selects even parity and 1 selects odd parity, counted over the data and parity bits together. A mismatch sets `par_err` along with `rx_valid`. At 9 data bits `cfg_par_en` has no effect, and the bit after the data is the stop bit.
- R6: A low stop bit sets `frame_err`. It does not set `rx_valid` and leaves `rx_data` unchanged.
- R7: When `rxd` is sampled low on more consecutive ticks than `len_cur` × (2 + data bits + parity bits), `brk` is set.
- R8: A write on `cfg_len_wr` loads `cfg_len_val` into `len_cur` only when the receiver is idle and the synchronised line is high, and only when the value is at least 4. Any other write leaves `len_cur` unchanged.
- R9: A start is qualified once the line has been low for exactly `len_cur` >> 1 consecutive ticks.
- R10: All flags stay set until `ack` is pulsed. An `ack` clears every flag, unless a new event sets that flag in the same cycle.
- R11: If a character completes while `rx_valid` is still set and no `ack` arrives in that cycle, `overrun` is set and `rx_data` takes the new character.
- R12: After a low stop bit, the receiver waits for the line to return high before it accepts a new start. It then receives the next character normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_tick | input | 1 | One-cycle sample strobe |
| rxd | input | 1 | Asynchronous serial line |
| cfg_len_val | input | CW | Requested ticks per bit |
| cfg_len_wr | input | 1 | Write strobe for the ticks-per-bit value |
| cfg_bits | input | 4 | Data length select |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| ack | input | 1 | Host acknowledge, clears the flags |
| rx_data | output | 9 | Last good character |
| rx_valid | output | 1 | Character waiting |
| par_err | output | 1 | Parity mismatch seen |
| frame_err | output | 1 | Low stop bit seen |
| overrun | output | 1 | Character completed while the previous one was unread |
| brk | output | 1 | Line held low beyond a character time |
| busy | output | 1 | Receiver not idle |
| len_cur | output | CW | Ticks per bit in use |

## Verification
The assertions watch on every cycle that the ticks-per-bit value changes only after an idle, high-line cycle and never drops below its floor. They also check that a character ends in either a good completion or a framing error, never both. The remaining per-cycle checks are that flags hold until `ack` and are cleared by it, that overrun follows an unread completion, and that a rejected start leaves the receiver idle. The bench scenarios are the only place that shows the sampled values themselves. They cover LSB-first ordering, length clamping, parity outcomes, the half-bit start boundary and the break threshold in ticks. They also show that writes during a start candidate or mid-character are dropped and that the receiver rearms after a break.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_HOLD
  } rx_state_t;

  localparam int unsigned MIN_LEN = 4;

  // Half a bit time in ticks.
  function automatic int unsigned half_len(input int unsigned len);
    return len >> 1;
  endfunction

  // Map any requested length onto the supported 5..9 range.
  function automatic logic [3:0] fit_bits(input logic [3:0] req);
    if (req < 4'd5) return 4'd5;
    if (req > 4'd9) return 4'd9;
    return req;
  endfunction

  // A parity bit exists only below nine data bits.
  function automatic logic par_on(input logic en, input logic [3:0] bits);
    return en && (bits != 4'd9);
  endfunction

  // Ticks in one whole character: start, data, parity, stop.
  function automatic int unsigned frame_ticks(input int unsigned len,
                                              input int unsigned bits,
                                              input logic par);
    return len * (2 + bits + (par ? 1 : 0));
  endfunction

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd,
  output logic line_s
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
    end else begin
      meta_q <= rxd;
      sync_q <= meta_q;
    end
  end

  assign line_s = sync_q;
endmodule

// File: rtl/serial_rx_rate.sv
module serial_rx_rate import serial_rx_pkg::*; #(
  parameter int CW  = 8,
  parameter int OVS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          allow,
  input  logic [CW-1:0] val,
  output logic [CW-1:0] len,
  output logic          took
);
  localparam logic [CW-1:0] RST_LEN = CW'(OVS);
  localparam logic [CW-1:0] FLOOR   = CW'(MIN_LEN);

  logic [CW-1:0] len_q;

  assign took = wr && allow && (val >= FLOOR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    len_q <= RST_LEN;
    else if (took) len_q <= val;
  end

  assign len = len_q;
endmodule

// File: rtl/serial_rx_brk.sv
module serial_rx_brk import serial_rx_pkg::*; #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          line,
  input  logic [CW-1:0] len,
  input  logic [3:0]    bits,
  input  logic          par,
  output logic          brk_hit
);
  localparam int LRW = CW + 4;
  localparam logic [LRW-1:0] SAT = {LRW{1'b1}};

  logic [LRW-1:0] low_run;
  logic [LRW-1:0] limit;

  assign limit = LRW'(frame_ticks(32'(len), 32'(bits), par));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run <= '0;
      brk_hit <= 1'b0;
    end else begin
      brk_hit <= 1'b0;
      if (tick) begin
        if (line) begin
          low_run <= '0;
        end else begin
          if (low_run != SAT) low_run <= low_run + LRW'(1);
          if (low_run == limit) brk_hit <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/serial_rx_fsm.sv
module serial_rx_fsm import serial_rx_pkg::*; #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          line,
  input  logic [CW-1:0] len,
  input  logic [3:0]    cfg_bits,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  output rx_state_t     state_o,
  output logic [3:0]    cur_bits,
  output logic          cur_par,
  output logic          ev_char,
  output logic          ev_frame,
  output logic          ev_perr,
  output logic          ev_noise,
  output logic [8:0]    char_data
);
  rx_state_t     st;
  logic [CW-1:0] cnt;
  logic [3:0]    idx;
  logic [8:0]    sh;
  logic          acc;
  logic          perr_q;
  logic [CW-1:0] half;
  logic          bit_end;
  logic [3:0]    bits_fit;

  assign half     = CW'(half_len(32'(len)));
  assign bit_end  = (cnt == len - CW'(1));
  assign bits_fit = fit_bits(cfg_bits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      idx      <= '0;
      sh       <= '0;
      acc      <= 1'b0;
      perr_q   <= 1'b0;
      cur_bits <= 4'd8;
      cur_par  <= 1'b0;
      ev_char  <= 1'b0;
      ev_frame <= 1'b0;
      ev_perr  <= 1'b0;
      ev_noise <= 1'b0;
    end else begin
      ev_char  <= 1'b0;
      ev_frame <= 1'b0;
      ev_perr  <= 1'b0;
      ev_noise <= 1'b0;
      if (tick) begin
        unique case (st)
          ST_IDLE: begin
            if (!line) begin
              st       <= ST_START;
              cnt      <= CW'(1);
              sh       <= '0;
              perr_q   <= 1'b0;
              cur_bits <= bits_fit;
              cur_par  <= par_on(cfg_par_en, bits_fit);
              acc      <= cfg_par_odd;
            end
          end
          ST_START: begin
            if (line) begin
              st       <= ST_IDLE;
              ev_noise <= 1'b1;
            end else if (cnt == half - CW'(1)) begin
              st  <= ST_DATA;
              cnt <= '0;
              idx <= '0;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          ST_DATA: begin
            if (bit_end) begin
              cnt     <= '0;
              sh[idx] <= line;
              acc     <= acc ^ line;
              if (idx == cur_bits - 4'd1) st <= cur_par ? ST_PAR : ST_STOP;
              else                        idx <= idx + 4'd1;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          ST_PAR: begin
            if (bit_end) begin
              cnt    <= '0;
              perr_q <= acc ^ line;
              st     <= ST_STOP;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          ST_STOP: begin
            if (bit_end) begin
              cnt <= '0;
              if (line) begin
                ev_char <= 1'b1;
                ev_perr <= cur_par & perr_q;
                st      <= ST_IDLE;
              end else begin
                ev_frame <= 1'b1;
                st       <= ST_HOLD;
              end
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          ST_HOLD: begin
            if (line) st <= ST_IDLE;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign state_o   = st;
  assign char_data = sh;
endmodule

// File: rtl/serial_rx.sv
module serial_rx import serial_rx_pkg::*; #(
  parameter int CW  = 8,
  parameter int OVS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_tick,
  input  logic          rxd,
  input  logic [CW-1:0] cfg_len_val,
  input  logic          cfg_len_wr,
  input  logic [3:0]    cfg_bits,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  input  logic          ack,
  output logic [8:0]    rx_data,
  output logic          rx_valid,
  output logic          par_err,
  output logic          frame_err,
  output logic          overrun,
  output logic          brk,
  output logic          busy,
  output logic [CW-1:0] len_cur
);
  logic       line_s;
  logic       len_allow;
  logic       len_took;
  rx_state_t  state;
  logic [3:0] cur_bits;
  logic       cur_par;
  logic       ev_char;
  logic       ev_frame;
  logic       ev_perr;
  logic       ev_noise;
  logic       brk_hit;
  logic [8:0] char_data;

  serial_rx_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rxd    (rxd),
    .line_s (line_s)
  );

  assign len_allow = (state == ST_IDLE) && line_s;

  serial_rx_rate #(.CW(CW), .OVS(OVS)) u_rate (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (cfg_len_wr),
    .allow (len_allow),
    .val   (cfg_len_val),
    .len   (len_cur),
    .took  (len_took)
  );

  serial_rx_fsm #(.CW(CW)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (smp_tick),
    .line        (line_s),
    .len         (len_cur),
    .cfg_bits    (cfg_bits),
    .cfg_par_en  (cfg_par_en),
    .cfg_par_odd (cfg_par_odd),
    .state_o     (state),
    .cur_bits    (cur_bits),
    .cur_par     (cur_par),
    .ev_char     (ev_char),
    .ev_frame    (ev_frame),
    .ev_perr     (ev_perr),
    .ev_noise    (ev_noise),
    .char_data   (char_data)
  );

  serial_rx_brk #(.CW(CW)) u_brk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (smp_tick),
    .line    (line_s),
    .len     (len_cur),
    .bits    (cur_bits),
    .par     (cur_par),
    .brk_hit (brk_hit)
  );

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      par_err   <= 1'b0;
      frame_err <= 1'b0;
      overrun   <= 1'b0;
      brk       <= 1'b0;
    end else begin
      if (ack) begin
        rx_valid  <= 1'b0;
        par_err   <= 1'b0;
        frame_err <= 1'b0;
        overrun   <= 1'b0;
        brk       <= 1'b0;
      end
      if (ev_char) begin
        rx_data  <= char_data;
        rx_valid <= 1'b1;
        if (ev_perr) par_err <= 1'b1;
        if (rx_valid && !ack) overrun <= 1'b1;
      end
      if (ev_frame) frame_err <= 1'b1;
      if (brk_hit)  brk       <= 1'b1;
    end
  end
endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk import serial_rx_pkg::*; #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          line_s,
  input logic [CW-1:0] len_cur,
  input logic          ack,
  input logic          ev_char,
  input logic          ev_frame,
  input logic          ev_noise,
  input logic          brk_hit,
  input logic          rx_valid,
  input logic          frame_err,
  input logic          overrun,
  input logic          brk
);
  p_len_idle_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(len_cur) |-> $past(!busy && line_s));

  p_len_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
    len_cur >= CW'(MIN_LEN));

  p_one_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_char, ev_frame}));

  p_frame_no_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame && !rx_valid |=> !rx_valid);

  p_valid_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !ack |=> rx_valid);

  p_frame_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err && !ack |=> frame_err);

  p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !ev_char |=> !rx_valid);

  p_overrun_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_char && rx_valid && !ack |=> overrun && rx_valid);

  p_brk_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_hit |=> brk);

  p_noise_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_noise |-> !busy);
endmodule

bind serial_rx serial_rx_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .line_s    (line_s),
  .len_cur   (len_cur),
  .ack       (ack),
  .ev_char   (ev_char),
  .ev_frame  (ev_frame),
  .ev_noise  (ev_noise),
  .brk_hit   (brk_hit),
  .rx_valid  (rx_valid),
  .frame_err (frame_err),
  .overrun   (overrun),
  .brk       (brk)
);

// File: tb/test_serial_rx.sv
`timescale 1ns/1ps
module test_serial_rx;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          smp_tick;
  logic          rxd = 1'b1;
  logic [CW-1:0] cfg_len_val = '0;
  logic          cfg_len_wr = 1'b0;
  logic [3:0]    cfg_bits = 4'd8;
  logic          cfg_par_en = 1'b0;
  logic          cfg_par_odd = 1'b0;
  logic          ack = 1'b0;
  logic [8:0]    rx_data;
  logic          rx_valid, par_err, frame_err, overrun, brk, busy;
  logic [CW-1:0] len_cur;

  int n_run = 0;
  int n_bad = 0;
  int blen  = 8;
  bit done  = 1'b0;
  logic [1:0] tdiv = 2'd0;

  always #10 clk = ~clk;

  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign smp_tick = (tdiv == 2'd3);

  serial_rx #(.CW(CW), .OVS(8)) i_serial_rx (
    .clk(clk), .rst_n(rst_n), .smp_tick(smp_tick), .rxd(rxd),
    .cfg_len_val(cfg_len_val), .cfg_len_wr(cfg_len_wr), .cfg_bits(cfg_bits),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .ack(ack),
    .rx_data(rx_data), .rx_valid(rx_valid), .par_err(par_err),
    .frame_err(frame_err), .overrun(overrun), .brk(brk), .busy(busy),
    .len_cur(len_cur)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n * 4) @(negedge clk);
  endtask

  task automatic pulse_ack();
    @(negedge clk) ack = 1'b1;
    @(negedge clk) ack = 1'b0;
  endtask

  task automatic write_len(input int v);
    @(negedge clk);
    cfg_len_val = CW'(v);
    cfg_len_wr  = 1'b1;
    @(negedge clk) cfg_len_wr = 1'b0;
  endtask

  function automatic bit par_of(input logic [8:0] d, input int nb, input bit odd);
    bit p = odd;
    for (int i = 0; i < nb; i++) p ^= d[i];
    return p;
  endfunction

  task automatic send_frame(input logic [8:0] d, input int nb, input bit wp,
                            input bit pbit, input bit stop);
    @(negedge clk);
    rxd = 1'b0; wait_ticks(blen);
    for (int i = 0; i < nb; i++) begin rxd = d[i]; wait_ticks(blen); end
    if (wp) begin rxd = pbit; wait_ticks(blen); end
    rxd = stop; wait_ticks(blen);
    rxd = 1'b1; wait_ticks(2);
  endtask

  task automatic t_reset();
    check("R1 rx_valid", rx_valid, 0);
    check("R1 flags", {par_err, frame_err, overrun, brk}, 0);
    check("R1 busy", busy, 0);
    check("R1 len_cur", len_cur, 8);
  endtask

  task automatic t_basic();
    send_frame(9'h0A5, 8, 0, 0, 1);
    check("R3 valid", rx_valid, 1);
    check("R3 data A5", rx_data, 'hA5);
    check("R3 no errors", {par_err, frame_err}, 0);
    pulse_ack();
    send_frame(9'h001, 8, 0, 0, 1);
    check("R3 lsb first", rx_data, 'h01);
    pulse_ack();
    send_frame(9'h03C, 8, 0, 0, 1);
    check("R3 data 3C", rx_data, 'h3C);
    pulse_ack();
  endtask

  task automatic t_noise();
    @(negedge clk) rxd = 1'b0;
    wait_ticks(3);
    rxd = 1'b1;
    wait_ticks(2);
    check("R2 short pulse idle", busy, 0);
    wait_ticks(12);
    check("R2 no flags", {rx_valid, frame_err, par_err}, 0);
    rxd = 1'b0;
    wait_ticks(4);
    rxd = 1'b1;
    wait_ticks(1);
    check("R9 half-bit start qualifies", busy, 1);
    wait_ticks(90);
    check("R9 char after half start", rx_valid, 1);
    check("R9 data all ones", rx_data, 'hFF);
    pulse_ack();
  endtask

  task automatic t_len();
    cfg_bits = 4'd5;  send_frame(9'h015, 5, 0, 0, 1);
    check("R4 five bits", rx_data, 'h15); pulse_ack();
    cfg_bits = 4'd9;  send_frame(9'h1A5, 9, 0, 0, 1);
    check("R4 nine bits", rx_data, 'h1A5); pulse_ack();
    cfg_bits = 4'd2;  send_frame(9'h00B, 5, 0, 0, 1);
    check("R4 clamp low", rx_data, 'h0B);
    check("R4 clamp low no frame err", frame_err, 0); pulse_ack();
    cfg_bits = 4'd15; send_frame(9'h155, 9, 0, 0, 1);
    check("R4 clamp high", rx_data, 'h155); pulse_ack();
    cfg_bits = 4'd8;
  endtask

  task automatic t_parity();
    cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    send_frame(9'h007, 8, 1, par_of(9'h007, 8, 0), 1);
    check("R5 even ok", {rx_valid, par_err}, 2'b10); pulse_ack();
    send_frame(9'h007, 8, 1, ~par_of(9'h007, 8, 0), 1);
    check("R5 even bad", {rx_valid, par_err}, 2'b11); pulse_ack();
    cfg_par_odd = 1'b1;
    send_frame(9'h007, 8, 1, par_of(9'h007, 8, 1), 1);
    check("R5 odd ok", {rx_valid, par_err}, 2'b10); pulse_ack();
    send_frame(9'h007, 8, 1, ~par_of(9'h007, 8, 1), 1);
    check("R5 odd bad", {rx_valid, par_err}, 2'b11); pulse_ack();
    cfg_bits = 4'd9;
    send_frame(9'h0F0, 9, 0, 0, 1);
    check("R5 parity ignored at 9 bits", {rx_valid, frame_err, par_err}, 3'b100);
    check("R5 9-bit data", rx_data, 'h0F0); pulse_ack();
    cfg_bits = 4'd8; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
  endtask

  task automatic t_frame();
    send_frame(9'h05A, 8, 0, 0, 1); pulse_ack();
    send_frame(9'h033, 8, 0, 0, 0);
    check("R6 frame_err", frame_err, 1);
    check("R6 no valid", rx_valid, 0);
    check("R6 data kept", rx_data, 'h5A);
    pulse_ack();
    check("R10 frame_err cleared", frame_err, 0);
  endtask

  task automatic t_break();
    @(negedge clk) rxd = 1'b0;
    wait_ticks(70);
    check("R7 no break yet", brk, 0);
    wait_ticks(20);
    check("R7 break", brk, 1);
    check("R7 framing too", frame_err, 1);
    rxd = 1'b1;
    wait_ticks(4);
    pulse_ack();
    check("R10 break cleared", brk, 0);
    send_frame(9'h066, 8, 0, 0, 1);
    check("R12 rearm after break", rx_valid, 1);
    check("R12 data", rx_data, 'h66);
    pulse_ack();
  endtask

  task automatic t_rate();
    write_len(16);
    check("R8 load idle", len_cur, 16);
    blen = 16;
    fork
      send_frame(9'h0C3, 8, 0, 0, 1);
      begin wait_ticks(3); write_len(8); wait_ticks(30); write_len(8); end
    join
    check("R8 writes in frame ignored", len_cur, 16);
    check("R8 char at 16", rx_data, 'hC3);
    pulse_ack();
    write_len(3);
    check("R8 below floor ignored", len_cur, 16);
    write_len(8);
    check("R8 restore", len_cur, 8);
    blen = 8;
  endtask

  task automatic t_ack();
    cfg_par_en = 1'b1;
    send_frame(9'h011, 8, 1, ~par_of(9'h011, 8, 0), 1);
    wait_ticks(40);
    check("R10 flags held", {rx_valid, par_err}, 2'b11);
    pulse_ack();
    check("R10 ack clears", {rx_valid, par_err, frame_err, overrun, brk}, 0);
    cfg_par_en = 1'b0;
  endtask

  task automatic t_overrun();
    send_frame(9'h021, 8, 0, 0, 1);
    send_frame(9'h042, 8, 0, 0, 1);
    check("R11 overrun", overrun, 1);
    check("R11 newest data", rx_data, 'h42);
    pulse_ack();
    check("R11 overrun cleared", overrun, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_noise();
    t_len();
    t_parity();
    t_frame();
    t_break();
    t_rate();
    t_ack();
    t_overrun();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end
endmodule